// File: doc/BRIEF.md
# Divider Configuration Port for a Frequency Synthesizer

This block holds the settings that a frequency synthesizer's dividers read: a 9-bit feedback divide value, a 3-bit output divide code and a 2-bit diagnostic select. It offers two ways to write them. In the first, pin-strapped values are copied while an active-low parallel strobe is low, and they are frozen when that strobe rises. In the second, a 14-bit word is shifted in on a serial clock and then moved into the settings by a serial load strobe.

All strobes and serial pins are brought into a system clock domain through synchronizers. Their edges are detected there. A small state machine tracks which source owns the settings, using four states. ST_PAR_OPEN means the parallel strobe is low and the registers follow the pins. ST_PAR_HELD means the parallel values are frozen. ST_SER_OPEN means the serial load is high, so the registers follow each shift. ST_SER_HELD means the serial values are frozen.

The state machine has these transitions:
- The parallel strobe going low moves any state to ST_PAR_OPEN.
- ST_PAR_OPEN moves to ST_PAR_HELD when the strobe is released.
- A serial load rise moves ST_PAR_HELD or ST_SER_HELD to ST_SER_OPEN.
- A serial load fall moves ST_SER_OPEN to ST_SER_HELD.

The diagnostic select steers one of four sources onto a test pin. The block also flags whether the feedback value lies in the lockable window.

Top module: `synth_divcfg`

## Requirements
- R1: While the synchronized `par_load_n` is low, `m_val`/`n_code` follow `par_m`/`par_n`.
- R2: After `par_load_n` rises, `m_val`/`n_code` keep the latched values when `par_m`/`par_n` change later, until a serial load or a new low on `par_load_n`.
- R3: Each rising edge of `ser_clk` seen while `par_load_n` is high shifts `ser_data` into the LSB of a 14-bit shift register. Edges seen while `par_load_n` is low leave the shift register unchanged.
- R4: A rising edge of `ser_load` while `par_load_n` is high copies the shift register into the settings. Bits [13:12] go to the test select (first bit sent first), bits [11:9] to `n_code`, and bits [8:0] to `m_val`, so the last bit sent is M bit 0.
- R5: While `ser_load` stays high, every shift also updates the settings with the new shift register contents.
- R6: After `ser_load` falls, shifting leaves `m_val`, `n_code` and the test select unchanged.
- R7: In the serial states, `test_out` depends on the test select. 00 gives 0, 01 gives the synchronized `ser_data`, 10 gives `mdiv_out`, and 11 gives `fout_cmos`.
- R8: In the parallel states (ST_PAR_OPEN, ST_PAR_HELD), `test_out` is 0 whatever the test select holds.
- R9: `m_valid` is 1 exactly when 250 <= `m_val` <= 500.
- R10: Reset clears `m_val`, `n_code`, the test select and the shift register, and `test_out` is 0.
- R11: A low on `par_load_n` overrides a serial setting and returns the registers to pin tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_load_n | input | 1 | Active-low parallel load strobe (asynchronous) |
| par_m | input | 9 | Pin-strapped feedback divide value |
| par_n | input | 3 | Pin-strapped output divide code |
| ser_clk | input | 1 | Serial shift clock (asynchronous, sampled) |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe |
| mdiv_out | input | 1 | Feedback divider output, used as a test source |
| fout_cmos | input | 1 | Output clock, used as a test source |
| m_val | output | 9 | Active feedback divide value |
| n_code | output | 3 | Active output divide code |
| test_out | output | 1 | Diagnostic output |
| m_valid | output | 1 | Feedback value inside the lockable window |

## Verification
The assertions assume that each strobe or serial pin level lasts at least two system clocks. They also assume that `ser_data` is stable around the sampled rising edge of `ser_clk`, so that synchronizer delay never merges or splits an edge. The bench holds every serial and strobe level for four system clocks and changes `ser_data` only while `ser_clk` is low. It changes `par_m`/`par_n` only while `par_load_n` has been stable for several clocks.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
    typedef enum logic [1:0] {
        ST_PAR_OPEN,
        ST_PAR_HELD,
        ST_SER_OPEN,
        ST_SER_HELD
    } cfg_state_e;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
    parameter int                 WIDTH   = 4,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain[s] <= RST_VAL;
            else if (s == 0)
                chain[s] <= din;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] sr_q,
    output logic [WORD_W-1:0] sr_next
);
    assign sr_next = shift_en ? {sr_q[WORD_W-2:0], bit_in} : sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else
            sr_q <= sr_next;
    end
endmodule

// File: rtl/divcfg_ctrl.sv
module divcfg_ctrl
    import divcfg_pkg::*;
#(
    parameter int M_W = 9,
    parameter int N_W = 3,
    parameter int T_W = 2,
    localparam int WORD_W = M_W + N_W + T_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_lo,
    input  logic              ld_s,
    input  logic              ld_rise,
    input  logic              ld_fall,
    input  logic              clk_rise,
    input  logic [M_W-1:0]    par_m,
    input  logic [N_W-1:0]    par_n,
    input  logic [WORD_W-1:0] sr_next,
    output cfg_state_e        state,
    output logic [M_W-1:0]    m_q,
    output logic [N_W-1:0]    n_q,
    output logic [T_W-1:0]    t_q
);
    cfg_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_PAR_HELD;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (par_lo) begin
            state_nx = ST_PAR_OPEN;
        end else begin
            unique case (state)
                ST_PAR_OPEN: state_nx = ST_PAR_HELD;
                ST_PAR_HELD: if (ld_rise) state_nx = ST_SER_OPEN;
                ST_SER_OPEN: if (ld_fall) state_nx = ST_SER_HELD;
                ST_SER_HELD: if (ld_rise) state_nx = ST_SER_OPEN;
                default:     state_nx = ST_PAR_HELD;
            endcase
        end
    end

    // output registers: divider and test-select settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
            n_q <= '0;
            t_q <= '0;
        end else if (par_lo) begin
            m_q <= par_m;
            n_q <= par_n;
        end else if (ld_rise ||
                     (state == ST_SER_OPEN && ld_s && clk_rise)) begin
            {t_q, n_q, m_q} <= sr_next;
        end
    end
endmodule

// File: rtl/synth_divcfg.sv
module synth_divcfg
    import divcfg_pkg::*;
#(
    parameter int M_W         = 9,
    parameter int N_W         = 3,
    parameter int T_W         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int M_MIN       = 250,
    parameter int M_MAX       = 500
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           mdiv_out,
    input  logic           fout_cmos,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_code,
    output logic           test_out,
    output logic           m_valid
);
    localparam int WORD_W = M_W + N_W + T_W;

    logic [3:0]        async_in, sync_out;
    logic              par_lo_s, sc_s, sd_s, ld_s;
    logic              sc_d, ld_d;
    logic              clk_rise, ld_rise, ld_fall;
    logic [WORD_W-1:0] sr_q, sr_next;
    logic [T_W-1:0]    t_q;
    cfg_state_e        state;

    assign async_in = {par_load_n, ser_clk, ser_data, ser_load};

    divcfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(async_in), .dout(sync_out)
    );

    assign par_lo_s = ~sync_out[3];
    assign sc_s     = sync_out[2];
    assign sd_s     = sync_out[1];
    assign ld_s     = sync_out[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_d <= 1'b0;
            ld_d <= 1'b0;
        end else begin
            sc_d <= sc_s;
            ld_d <= ld_s;
        end
    end

    assign clk_rise = sc_s & ~sc_d;
    assign ld_rise  = ld_s & ~ld_d & ~par_lo_s;
    assign ld_fall  = ~ld_s & ld_d;

    divcfg_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_en(clk_rise & ~par_lo_s),
        .bit_in(sd_s), .sr_q(sr_q), .sr_next(sr_next)
    );

    divcfg_ctrl #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .par_lo(par_lo_s), .ld_s(ld_s),
        .ld_rise(ld_rise), .ld_fall(ld_fall), .clk_rise(clk_rise),
        .par_m(par_m), .par_n(par_n), .sr_next(sr_next),
        .state(state), .m_q(m_val), .n_q(n_code), .t_q(t_q)
    );

    // diagnostic multiplexer, forced low in the parallel states
    always_comb begin
        test_out = 1'b0;
        if (state == ST_SER_OPEN || state == ST_SER_HELD) begin
            unique case (t_q)
                2'b00:   test_out = 1'b0;
                2'b01:   test_out = sd_s;
                2'b10:   test_out = mdiv_out;
                default: test_out = fout_cmos;
            endcase
        end
    end

    assign m_valid = (int'(m_val) >= M_MIN) && (int'(m_val) <= M_MAX);
endmodule

// File: rtl/divcfg_chk.sv
module divcfg_chk
    import divcfg_pkg::*;
#(
    parameter int M_W = 9,
    parameter int N_W = 3,
    parameter int T_W = 2,
    localparam int WORD_W = M_W + N_W + T_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              par_lo,
    input logic              ld_s,
    input logic              ld_rise,
    input logic              clk_rise,
    input logic              sd_s,
    input logic [WORD_W-1:0] sr_q,
    input logic [M_W-1:0]    par_m,
    input logic [M_W-1:0]    m_val,
    input logic [N_W-1:0]    n_code,
    input logic [T_W-1:0]    t_q,
    input cfg_state_e        state,
    input logic              test_out
);
    logic pass_shift;
    assign pass_shift = (state == ST_SER_OPEN) && ld_s && clk_rise;

    assert_par_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
        par_lo |=> m_val == $past(par_m));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_lo && !ld_rise && !pass_shift) |=> $stable(m_val));

    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_rise && !par_lo) |=> sr_q == {$past(sr_q[WORD_W-2:0]), $past(sd_s)});

    assert_shift_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_rise || par_lo) |=> $stable(sr_q));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rise && !clk_rise && !par_lo) |=> {t_q, n_code, m_val} == $past(sr_q));

    assert_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_shift && !par_lo) |=> m_val == $past({sr_q[M_W-2:0], sd_s}));

    assert_par_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAR_OPEN || state == ST_PAR_HELD) |-> !test_out);
endmodule

bind synth_divcfg divcfg_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .par_lo(par_lo_s), .ld_s(ld_s),
    .ld_rise(ld_rise), .clk_rise(clk_rise), .sd_s(sd_s), .sr_q(sr_q),
    .par_m(par_m), .m_val(m_val), .n_code(n_code), .t_q(t_q),
    .state(state), .test_out(test_out)
);

// File: tb/tb_synth_divcfg.sv
module tb_synth_divcfg;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {expected m_valid, T[1:0], N[2:0], M[8:0]}
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b1, 2'b01, 3'b010, 9'd250},
        {1'b0, 2'b10, 3'b101, 9'd249},
        {1'b1, 2'b11, 3'b111, 9'd500},
        {1'b0, 2'b00, 3'b000, 9'd501},
        {1'b1, 2'b01, 3'b011, 9'd300},
        {1'b0, 2'b10, 3'b001, 9'd0}
    };

    logic       clk = 0, rst_n = 0;
    logic       par_load_n = 1, ser_clk = 0, ser_data = 0, ser_load = 0;
    logic       mdiv_out = 0, fout_cmos = 0;
    logic [8:0] par_m = '0, m_val;
    logic [2:0] par_n = '0, n_code;
    logic       test_out, m_valid;
    int         n_chk = 0, n_bad = 0;

    synth_divcfg dut (
        .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
        .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .mdiv_out(mdiv_out), .fout_cmos(fout_cmos),
        .m_val(m_val), .n_code(n_code), .test_out(test_out), .m_valid(m_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_data = b; wait_clk(4);
        ser_clk  = 1; wait_clk(4);
        ser_clk  = 0; wait_clk(4);
    endtask

    task automatic send_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) send_bit(w[i]);
    endtask

    function automatic logic exp_test(input logic [1:0] t, input logic sd,
                                      input logic md, input logic fo);
        case (t)
            2'b00:   return 1'b0;
            2'b01:   return sd;
            2'b10:   return md;
            default: return fo;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [8:0]  held_m;
        logic [13:0] w;
        mdiv_out = 1; fout_cmos = 1;
        wait_clk(3); rst_n = 1; wait_clk(4);
        // R10 reset state
        check("R10 m", m_val, 0);
        check("R10 n", n_code, 0);
        check("R10 test", test_out, 0);
        check("R9 valid at reset", m_valid, 0);

        // R1 parallel tracking
        par_m = 9'd321; par_n = 3'd5; par_load_n = 0; wait_clk(6);
        check("R1 m", m_val, 321);
        check("R1 n", n_code, 5);
        par_m = 9'd400; par_n = 3'd2; wait_clk(6);
        check("R1 m follows", m_val, 400);
        check("R1 n follows", n_code, 2);
        check("R9 valid 400", m_valid, 1);
        check("R8 test parallel", test_out, 0);
        par_load_n = 1; wait_clk(6);
        par_m = 9'd100; par_n = 3'd7; wait_clk(6);
        check("R2 m held", m_val, 400);
        check("R2 n held", n_code, 2);

        // vector table: serial loads
        held_m = 9'd400;
        for (int v = 0; v < NVEC; v++) begin
            send_word(VEC[v][13:0]);
            check("R6 no change before load", m_val, held_m);
            ser_load = 1; wait_clk(6);
            check("R4 m", m_val, VEC[v][8:0]);
            check("R4 n", n_code, VEC[v][11:9]);
            check("R9 valid", m_valid, VEC[v][14]);
            ser_data = 1; mdiv_out = 1; fout_cmos = 0; wait_clk(6);
            check("R7 test mux", test_out, exp_test(VEC[v][13:12], 1'b1, 1'b1, 1'b0));
            ser_load = 0; wait_clk(6);
            held_m = VEC[v][8:0];
        end

        // R11 parallel override of serial setting (T is 10 now)
        mdiv_out = 1; fout_cmos = 1;
        par_m = 9'd260; par_n = 3'd3; par_load_n = 0; wait_clk(6);
        check("R11 m", m_val, 260);
        check("R11 n", n_code, 3);
        check("R8 test forced low", test_out, 0);
        // R3 shifts while parallel strobe low are ignored
        send_word(14'h3FFF);
        par_load_n = 1; wait_clk(6);
        ser_load = 1; wait_clk(6);
        check("R3 sr kept m", m_val, VEC[NVEC-1][8:0]);
        check("R3 sr kept n", n_code, VEC[NVEC-1][11:9]);

        // R5 pass-through while ser_load high
        w = {VEC[NVEC-1][12:0], 1'b1};
        send_bit(1'b1);
        check("R5 m step1", m_val, w[8:0]);
        check("R5 n step1", n_code, w[11:9]);
        w = {w[12:0], 1'b0};
        send_bit(1'b0);
        check("R5 m step2", m_val, w[8:0]);

        // R6 latch on ser_load fall
        ser_load = 0; wait_clk(6);
        send_bit(1'b1); send_bit(1'b1);
        check("R6 m latched", m_val, w[8:0]);
        check("R6 n latched", n_code, w[11:9]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule